// File: doc/BRIEF.md
# Eight-Bit Multifunction ALU

This block is a purely combinational arithmetic-logic unit for two 8-bit two's-complement operands. A 3-bit operation select chooses one of eight functions: addition, subtraction, four bitwise operations, and two signed comparisons. The block drives an 8-bit result and a signed-overflow flag. It has no clock and holds no state, so the outputs follow the current inputs.

A surrounding datapath presents both operands and the select, then takes the result and overflow in the same cycle. The two compare selects return a single truth bit in result bit 0 and clear every other result bit, so the result can be used directly as a boolean. The overflow flag is meaningful only for addition and subtraction. It is held low for every other select.

Top module: `alu8_top`

## Requirements
- R1: Select 3'b000 drives the result with the low 8 bits of op_x + op_y.
- R2: Select 3'b001 drives the result with the low 8 bits of op_x − op_y.
- R3: For select 3'b000, ovf_o is 1 exactly when the operands share a sign bit (bit 7) and the sum's bit 7 differs from it.
- R4: For select 3'b001, ovf_o is 1 exactly when the operands' bit 7 differ and the difference's bit 7 differs from op_x bit 7.
- R5: Select 3'b010 gives op_x AND op_y bitwise, and select 3'b011 gives op_x OR op_y bitwise.
- R6: Select 3'b100 gives the bitwise inverse of op_x, and op_y has no effect on the result.
- R7: Select 3'b101 gives op_x XOR op_y bitwise.
- R8: Select 3'b110 sets result bit 0 to 1 when op_x < op_y as signed values and to 0 otherwise. Bits 7..1 are 0. The answer is correct even when op_x − op_y overflows.
- R9: Select 3'b111 sets result bit 0 to 1 when op_x ≥ op_y as signed values and to 0 otherwise. Bits 7..1 are 0.
- R10: ovf_o is 0 for every select other than 3'b000 and 3'b001.
- R11: No combination of known inputs produces an unknown bit on result_o or ovf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | 8 | First operand, two's complement |
| op_y | input | 8 | Second operand, two's complement |
| op_sel | input | 3 | Operation select |
| result_o | output | 8 | Operation result |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The bench sweeps every operand pair under every select, so every sign combination at the overflow boundary is covered. This includes 127+1, −128−1 and −128−(−128). An overflow rule that tested the carry out, or that used y's sign in place of the effective addend's sign during subtraction, fails on these pairs. The signed compares are driven across the full range, including pairs where the raw difference wraps, such as 127 vs −1. A compare built from the difference's sign bit alone gives the inverted answer there, and an unsigned compare fails whenever the operands have different signs. Running NOT with y varied over all values exposes any leak of y into that function.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ALU_W = 8;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_NOT = 3'b100,
        OP_XOR = 3'b101,
        OP_LT  = 3'b110,
        OP_GE  = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        LF_AND = 2'b00,
        LF_OR  = 2'b01,
        LF_XOR = 2'b10,
        LF_NOT = 2'b11
    } logic_fn_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff_d;

    always_comb begin
        // Subtraction: invert b and add one through the carry-in.
        b_eff_d = sub_i ? ~b_i : b_i;
        sum_o   = a_i + b_eff_d + W'(sub_i);
        // Signed overflow: the addends agree in sign and the sum disagrees.
        ovf_o   = (a_i[W-1] == b_eff_d[W-1]) && (sum_o[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_fn_e    fn_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (fn_i)
            LF_AND:  res_o = a_i & b_i;
            LF_OR:   res_o = a_i | b_i;
            LF_XOR:  res_o = a_i ^ b_i;
            LF_NOT:  res_o = ~a_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_scmp.sv
module alu8_scmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         lt_o
);
    logic [W:0] diff_d;

    always_comb begin
        // Sign-extend by one bit so the difference cannot wrap.
        diff_d = {a_i[W-1], a_i} - {b_i[W-1], b_i};
        lt_o   = diff_d[W];
    end
endmodule

// File: rtl/alu8_top.sv
module alu8_top
    import alu8_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic [2:0]   op_sel,
    output logic [W-1:0] result_o,
    output logic         ovf_o
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         ovf;
    } alu_out_t;

    alu_op_e      op_d;
    logic         sub_d;
    logic [W-1:0] arith_d;
    logic         arith_ovf_d;
    logic_fn_e    lfn_d;
    logic [W-1:0] logic_d;
    logic         lt_d;
    alu_out_t     out_d;

    always_comb begin
        op_d  = alu_op_e'(op_sel);
        sub_d = (op_d == OP_SUB);
        unique case (op_d)
            OP_AND:  lfn_d = LF_AND;
            OP_OR:   lfn_d = LF_OR;
            OP_XOR:  lfn_d = LF_XOR;
            OP_NOT:  lfn_d = LF_NOT;
            default: lfn_d = LF_AND;
        endcase
    end

    alu8_addsub #(.W(W)) addsub_i (
        .a_i   (op_x),
        .b_i   (op_y),
        .sub_i (sub_d),
        .sum_o (arith_d),
        .ovf_o (arith_ovf_d)
    );

    alu8_bitwise #(.W(W)) bitwise_i (
        .a_i   (op_x),
        .b_i   (op_y),
        .fn_i  (lfn_d),
        .res_o (logic_d)
    );

    alu8_scmp #(.W(W)) scmp_i (
        .a_i  (op_x),
        .b_i  (op_y),
        .lt_o (lt_d)
    );

    always_comb begin
        out_d = '0;
        unique case (op_d)
            OP_ADD, OP_SUB: begin
                out_d.res = arith_d;
                out_d.ovf = arith_ovf_d;
            end
            OP_AND, OP_OR, OP_NOT, OP_XOR: out_d.res = logic_d;
            OP_LT:   out_d.res = {{(W-1){1'b0}}, lt_d};
            OP_GE:   out_d.res = {{(W-1){1'b0}}, ~lt_d};
            default: out_d = '0;
        endcase
    end

    assign result_o = out_d.res;
    assign ovf_o    = out_d.ovf;
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
    parameter int W = 8
) (
    input logic [W-1:0] op_x,
    input logic [W-1:0] op_y,
    input logic [2:0]   op_sel,
    input logic [W-1:0] result_o,
    input logic         ovf_o
);
    always_comb begin
        if (op_sel[2] || op_sel[1]) begin
            a_r10_no_overflow: assert (ovf_o == 1'b0);
        end
        if (op_sel[2:1] == 2'b11) begin
            a_r8_cmp_upper_zero: assert (result_o[W-1:1] == '0);
        end
        if (op_sel == 3'b110 && op_x == op_y) begin
            a_r8_lt_equal_false: assert (result_o[0] == 1'b0);
        end
        if (op_sel == 3'b111 && op_x == op_y) begin
            a_r9_ge_equal_true: assert (result_o[0] == 1'b1);
        end
        if (op_sel == 3'b100) begin
            a_r6_not_complement: assert ((result_o ^ op_x) == '1);
        end
        if (op_sel == 3'b000 && op_y == '0) begin
            a_r1_add_zero_identity: assert (result_o == op_x && !ovf_o);
        end
        a_r11_known_outputs: assert (!$isunknown({op_x, op_y, op_sel}) ->
                                     !$isunknown({result_o, ovf_o}));
    end
endmodule

bind alu8_top alu8_checker #(.W(W)) chk_i (
    .op_x     (op_x),
    .op_y     (op_y),
    .op_sel   (op_sel),
    .result_o (result_o),
    .ovf_o    (ovf_o)
);

// File: tb/alu8_top_tb_top.sv
`timescale 1ns/1ps
module alu8_top_tb_top;

    logic       clk = 1'b0;
    logic [7:0] op_x = '0;
    logic [7:0] op_y = '0;
    logic [2:0] op_sel = '0;
    logic [7:0] result_o;
    logic       ovf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    alu8_top dut_i (
        .op_x     (op_x),
        .op_y     (op_y),
        .op_sel   (op_sel),
        .result_o (result_o),
        .ovf_o    (ovf_o)
    );

    task automatic check(input string tag, input logic [7:0] got_r, input logic [7:0] exp_r,
                         input logic got_o, input logic exp_o);
        n_chk++;
        if (got_r !== exp_r || got_o !== exp_o) begin
            n_bad++;
            $display("FAIL %s sel=%b x=%02h y=%02h: got res=%02h ovf=%b, expected res=%02h ovf=%b",
                     tag, op_sel, op_x, op_y, got_r, got_o, exp_r, exp_o);
        end
    endtask

    initial begin
        // Quiet state: all-zero inputs give zero result and no overflow (R1).
        #1;
        check("R1", result_o, 8'h00, ovf_o, 1'b0);

        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    logic signed [7:0] xs;
                    logic signed [7:0] ys;
                    int          wide;
                    logic [7:0]  er;
                    logic        eo;
                    string       tag;
                    xs = 8'(a);
                    ys = 8'(b);
                    er = '0;
                    eo = 1'b0;
                    case (s)
                        0: begin wide = int'(xs) + int'(ys); er = 8'(wide);
                                 eo = (wide > 127) || (wide < -128); tag = "R1/R3"; end
                        1: begin wide = int'(xs) - int'(ys); er = 8'(wide);
                                 eo = (wide > 127) || (wide < -128); tag = "R2/R4"; end
                        2: begin er = 8'(a) & 8'(b); tag = "R5"; end
                        3: begin er = 8'(a) | 8'(b); tag = "R5"; end
                        4: begin er = 8'(255 - a); tag = "R6"; end
                        5: begin er = 8'(a) ^ 8'(b); tag = "R7"; end
                        6: begin er = (int'(xs) < int'(ys)) ? 8'd1 : 8'd0; tag = "R8"; end
                        default: begin er = (int'(xs) >= int'(ys)) ? 8'd1 : 8'd0; tag = "R9"; end
                    endcase
                    op_sel = 3'(s);
                    op_x   = 8'(a);
                    op_y   = 8'(b);
                    #1;
                    check(tag, result_o, er, ovf_o, eo);
                    if (s >= 2) begin
                        // R10: overflow quiet outside add/subtract
                        n_chk++;
                        if (ovf_o !== 1'b0) begin
                            n_bad++;
                            $display("FAIL R10 sel=%0d: ovf=%b expected 0", s, ovf_o);
                        end
                    end
                    n_chk++;
                    if ($isunknown({result_o, ovf_o})) begin
                        n_bad++;
                        $display("FAIL R11 sel=%0d: res=%b ovf=%b expected known", s, result_o, ovf_o);
                    end
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run incomplete, expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule